// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between an asynchronous-style memory bus and the internals of a two-partition flash array. Writes on the bus carry byte-wide command codes. The controller checks that each command arrives as its exact one- or two-write sequence. It tracks which kind of data a bus read should return: array contents, a partition status byte, identifier words or query bytes. When a program or erase sequence is complete, it launches a job on a write-engine stub.

The write engine here is a placeholder. It stays busy for a fixed, parameterised number of clocks. A job can be suspended, which freezes its countdown, and resumed later. While a job is counting, the controller accepts only the status-read and suspend commands. Each partition has its own status byte, and the top address bit selects which one a status read returns. Bit 7 of that byte shows whether the engine is ready.

Bus strobes are sampled on the system clock. One bus write is counted on the first clock where the write condition holds. A read is combinational for as long as the read condition holds.

Top module: `fcmd_ctrl`

## Requirements
- R1: After `rst`, the controller is in array-read mode, no job is running, and both status bytes read 80h.
- R2: A write is recognised only while `bus_ce_n`=0, `bus_we_n`=0, `bus_oe_n`=1 and `bus_rst_n`=1. `bus_rdata` is zero unless `bus_ce_n`=0, `bus_oe_n`=0, `bus_we_n`=1 and `bus_rst_n`=1.
- R3: Code FFh selects array-read mode, in which reads return `array_rdata` and `array_addr` follows `bus_addr`.
- R4: Code 70h selects status mode. A read returns bits 15:8 as zero and bits 7:0 as the status byte of the partition chosen by `bus_addr[ADDR_W-1]`. Status bit layout: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 2 program suspended, 3/1/0 zero.
- R5: 10h, 40h or C0h followed by any write starts a program job in the partition of the second write's address. `eng_busy` then rises for exactly BUSY_CYCLES clocks. The controller enters status mode, and that partition's bit 7 reads 0 during the job.
- R6: 20h followed by D0h starts an erase job of the same length and enters status mode.
- R7: 20h followed by any byte other than D0h starts no job. It sets bits 5 and 4 of the partition addressed by the second write and enters status mode.
- R8: While a job counts, every code except 70h and B0h is ignored.
- R9: B0h during a counting job freezes the countdown and sets bit 6 (erase) or bit 2 (program) with bit 7 high. While suspended, FFh, 70h, 90h and 98h change the read mode. D0h clears the suspend bit and continues the countdown.
- R10: Code 50h, when idle, clears bits 5:1 of both status bytes and leaves bit 7 unchanged.
- R11: Code 90h selects identifier mode: `bus_addr[0]`=0 reads MAKER_ID and 1 reads DEVICE_ID. Code 98h selects query mode: `bus_addr[1:0]` of 0, 1, 2, 3 reads 0051h, 0052h, 0059h, 0000h.
- R12: `bus_rst_n` low for a clock aborts any job, clears both error sets and returns to array-read mode.
- R13: Code 60h consumes the following write without starting a job and leaves the controller in array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_rst_n | input | 1 | Bus-side reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 8 | Command / data byte |
| bus_rdata | output | 16 | Read data |
| array_rdata | input | 16 | Word from the array storage |
| array_addr | output | ADDR_W | Address passed to the array storage |
| eng_busy | output | 1 | Write-engine job in progress (also while suspended) |

## Verification
The hardest state to reach is a suspended job that is then resumed. The stimulus has to complete an erase or program sequence and land a B0h write inside the busy window. It must then confirm that the countdown stays frozen over a span several times longer than a job, issue read-mode changes that are legal only in the suspended state, and resume with D0h. The bench checks the suspended status pattern for both job types. It then waits out the remaining count and confirms the partition's ready bit returns.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_IDENT  = 2'd2,
        MD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        PD_NONE  = 2'd0,
        PD_PROG  = 2'd1,
        PD_ERASE = 2'd2,
        PD_PROT  = 2'd3
    } pend_e;

    typedef enum logic [3:0] {
        CM_NONE,
        CM_PROG,
        CM_ERASE,
        CM_CLEAR,
        CM_PROT,
        CM_RDSR,
        CM_RDID,
        CM_QUERY,
        CM_SUSP,
        CM_PRREG,
        CM_CONF,
        CM_RDARR
    } cmd_e;

    typedef struct packed {
        logic ers_err;
        logic prg_err;
    } err_flags_t;

    typedef struct packed {
        logic running;
        logic susp;
        logic erase;
        logic part;
    } job_state_t;

    function automatic cmd_e classify(input logic [7:0] code);
        cmd_e c;
        case (code)
            8'h10, 8'h40: c = CM_PROG;
            8'h20:        c = CM_ERASE;
            8'h50:        c = CM_CLEAR;
            8'h60:        c = CM_PROT;
            8'h70:        c = CM_RDSR;
            8'h90:        c = CM_RDID;
            8'h98:        c = CM_QUERY;
            8'hB0:        c = CM_SUSP;
            8'hC0:        c = CM_PRREG;
            8'hD0:        c = CM_CONF;
            8'hFF:        c = CM_RDARR;
            default:      c = CM_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] query_byte(input logic [1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = 8'h51;
            2'd1:    b = 8'h52;
            2'd2:    b = 8'h59;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] pack_status(input logic ready, input logic e_susp,
                                               input err_flags_t e, input logic p_susp);
        return {ready, e_susp, e.ers_err, e.prg_err, 1'b0, p_susp, 2'b00};
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       rst_n,
    input  logic [7:0] wdata,
    output logic       wr_evt,
    output logic       rd_act,
    output cmd_e       cmd
);
    logic wr_cond;
    logic wr_seen_q;

    assign wr_cond = !ce_n && !we_n && oe_n && rst_n;
    assign rd_act  = !ce_n && !oe_n && we_n && rst_n;

    always_ff @(posedge clk) begin
        if (rst) wr_seen_q <= 1'b0;
        else     wr_seen_q <= wr_cond;
    end

    // one event per write strobe: the first sampled clock of the low phase
    assign wr_evt = wr_cond && !wr_seen_q;
    assign cmd    = classify(wdata);
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine
    import fcmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 16,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_erase,
    input  logic             start_part,
    input  logic             suspend,
    input  logic             resume,
    output job_state_t       job,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

    always_ff @(posedge clk) begin
        if (rst) begin
            job <= '0;
            cnt <= '0;
        end else if (start) begin
            job.running <= 1'b1;
            job.susp    <= 1'b0;
            job.erase   <= start_erase;
            job.part    <= start_part;
            cnt         <= LOAD;
        end else if (job.running) begin
            if (suspend)     job.susp <= 1'b1;
            else if (resume) job.susp <= 1'b0;
            if (!job.susp) begin
                if (cnt == CNT_W'(1)) begin
                    job.running <= 1'b0;
                    cnt         <= '0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
#(
    parameter int NPART = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_err,
    input  logic                  err_part,
    input  logic                  clr_err,
    input  job_state_t            job,
    output logic [NPART-1:0][7:0] sr
);
    for (genvar p = 0; p < NPART; p++) begin : g_part
        err_flags_t err_q;
        logic       owns_job;
        logic       ready;

        always_ff @(posedge clk) begin
            if (rst || clr_err) begin
                err_q <= '0;
            end else if (set_err && (err_part == 1'(p))) begin
                err_q.ers_err <= 1'b1;
                err_q.prg_err <= 1'b1;
            end
        end

        assign owns_job = job.running && (job.part == 1'(p));
        assign ready    = !(owns_job && !job.susp);
        assign sr[p]    = pack_status(ready,
                                      owns_job && job.susp && job.erase,
                                      err_q,
                                      owns_job && job.susp && !job.erase);
    end
endmodule

// File: rtl/fcmd_rdmux.sv
module fcmd_rdmux
    import fcmd_pkg::*;
#(
    parameter int NPART = 2,
    parameter logic [15:0] MAKER_ID  = 16'h00E5,
    parameter logic [15:0] DEVICE_ID = 16'h7A31
) (
    input  logic                  rd_act,
    input  rd_mode_e              mode,
    input  logic                  part_sel,
    input  logic [1:0]            addr_lo,
    input  logic [NPART-1:0][7:0] sr,
    input  logic [15:0]           array_rdata,
    output logic [15:0]           rdata
);
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            case (mode)
                MD_ARRAY:  rdata = array_rdata;
                MD_STATUS: rdata = {8'h00, sr[part_sel]};
                MD_IDENT:  rdata = addr_lo[0] ? DEVICE_ID : MAKER_ID;
                MD_QUERY:  rdata = {8'h00, query_byte(addr_lo)};
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          BUSY_CYCLES = 16,
    parameter logic [15:0] MAKER_ID    = 16'h00E5,
    parameter logic [15:0] DEVICE_ID   = 16'h7A31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic              bus_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       array_rdata,
    output logic [ADDR_W-1:0] array_addr,
    output logic              eng_busy
);
    localparam int NPART = 2;
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic             soft_rst;
    logic             wr_evt, rd_act;
    cmd_e             cmd;
    logic             part_sel;
    rd_mode_e         mode_q, mode_d;
    pend_e            pend_q, pend_d;
    job_state_t       job;
    logic [CNT_W-1:0] cnt;
    logic             start, start_erase, suspend, resume, set_err, clr_err;
    logic [NPART-1:0][7:0] sr;

    assign soft_rst   = rst || !bus_rst_n;
    assign part_sel   = bus_addr[ADDR_W-1];
    assign array_addr = bus_addr;
    assign eng_busy   = job.running;

    fcmd_decode u_dec (
        .clk(clk), .rst(soft_rst),
        .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n), .rst_n(bus_rst_n),
        .wdata(bus_wdata),
        .wr_evt(wr_evt), .rd_act(rd_act), .cmd(cmd)
    );

    // command sequencing
    always_comb begin
        mode_d      = mode_q;
        pend_d      = pend_q;
        start       = 1'b0;
        start_erase = 1'b0;
        suspend     = 1'b0;
        resume      = 1'b0;
        set_err     = 1'b0;
        clr_err     = 1'b0;
        if (wr_evt) begin
            if (pend_q != PD_NONE) begin
                pend_d = PD_NONE;
                case (pend_q)
                    PD_PROG: begin
                        start  = 1'b1;
                        mode_d = MD_STATUS;
                    end
                    PD_ERASE: begin
                        if (cmd == CM_CONF) begin
                            start       = 1'b1;
                            start_erase = 1'b1;
                        end else begin
                            set_err = 1'b1;
                        end
                        mode_d = MD_STATUS;
                    end
                    default: mode_d = MD_ARRAY;
                endcase
            end else if (job.running && !job.susp) begin
                case (cmd)
                    CM_RDSR: mode_d = MD_STATUS;
                    CM_SUSP: begin
                        suspend = 1'b1;
                        mode_d  = MD_STATUS;
                    end
                    default: ;
                endcase
            end else if (job.running) begin
                case (cmd)
                    CM_RDSR:  mode_d = MD_STATUS;
                    CM_RDARR: mode_d = MD_ARRAY;
                    CM_RDID:  mode_d = MD_IDENT;
                    CM_QUERY: mode_d = MD_QUERY;
                    CM_CONF: begin
                        resume = 1'b1;
                        mode_d = MD_STATUS;
                    end
                    default: ;
                endcase
            end else begin
                case (cmd)
                    CM_PROG, CM_PRREG: pend_d = PD_PROG;
                    CM_ERASE:          pend_d = PD_ERASE;
                    CM_PROT:           pend_d = PD_PROT;
                    CM_CLEAR:          clr_err = 1'b1;
                    CM_RDSR:           mode_d = MD_STATUS;
                    CM_RDARR:          mode_d = MD_ARRAY;
                    CM_RDID:           mode_d = MD_IDENT;
                    CM_QUERY:          mode_d = MD_QUERY;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            mode_q <= MD_ARRAY;
            pend_q <= PD_NONE;
        end else begin
            mode_q <= mode_d;
            pend_q <= pend_d;
        end
    end

    fcmd_engine #(.BUSY_CYCLES(BUSY_CYCLES)) u_eng (
        .clk(clk), .rst(soft_rst),
        .start(start), .start_erase(start_erase), .start_part(part_sel),
        .suspend(suspend), .resume(resume),
        .job(job), .cnt(cnt)
    );

    fcmd_status #(.NPART(NPART)) u_sr (
        .clk(clk), .rst(soft_rst),
        .set_err(set_err), .err_part(part_sel), .clr_err(clr_err),
        .job(job), .sr(sr)
    );

    fcmd_rdmux #(.NPART(NPART), .MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)) u_rd (
        .rd_act(rd_act), .mode(mode_q), .part_sel(part_sel),
        .addr_lo(bus_addr[1:0]), .sr(sr),
        .array_rdata(array_rdata), .rdata(bus_rdata)
    );
endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rst_n,
    input logic             wr_evt,
    input logic             rd_act,
    input logic [7:0]       code,
    input logic [1:0]       mode,
    input logic [1:0]       pend,
    input logic             susp,
    input logic [CNT_W-1:0] cnt,
    input logic [15:0]      bus_rdata,
    input logic             eng_busy
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode == 2'd0) && !eng_busy);

    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_act |-> bus_rdata == 16'h0000);

    assert_status_high_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_act && mode == 2'd1) |-> bus_rdata[15:8] == 8'h00);

    assert_job_from_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |-> $past(wr_evt));

    assert_bad_confirm_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_evt && pend == 2'd2 && code != 8'hD0 && !eng_busy) |=> !eng_busy && mode == 2'd1);

    assert_busy_lockout_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_evt && eng_busy && !susp && code != 8'h70 && code != 8'hB0) |=> mode == $past(mode));

    assert_frozen_count_R9: assert property (@(posedge clk) disable iff (rst)
        (susp && $past(susp)) |-> cnt == $past(cnt));

    assert_bus_reset_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rst_n |=> !eng_busy && mode == 2'd0);
endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n),
    .wr_evt(wr_evt), .rd_act(rd_act), .code(bus_wdata),
    .mode(mode_q), .pend(pend_q), .susp(job.susp), .cnt(cnt),
    .bus_rdata(bus_rdata), .eng_busy(eng_busy)
);

// File: tb/sim_fcmd_ctrl.sv
`timescale 1ns/1ps
module sim_fcmd_ctrl;
    localparam int N = 16;
    localparam logic [15:0] ARR = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, brst_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] rdata;
    logic [15:0] arr_data = ARR;
    logic [7:0]  arr_addr;
    logic        busy;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    fcmd_ctrl #(.ADDR_W(8), .BUSY_CYCLES(N)) u0 (
        .clk(clk), .rst(rst),
        .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n), .bus_rst_n(brst_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .array_rdata(arr_data), .array_addr(arr_addr), .eng_busy(busy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 v = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * N && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        check("R1 busy after reset", 16'(busy), 16'h0);
        check("R2 idle bus drives zero", rdata, 16'h0);
        rd(8'h12, v);
        check("R1 array mode after reset", v, ARR);
        check("R3 array address follows bus", 16'(arr_addr), 16'h0012);
        wr(8'h00, 8'h70);
        rd(8'h00, v);
        check("R4 part0 status after reset", v, 16'h0080);
        rd(8'h80, v);
        check("R4 part1 status after reset", v, 16'h0080);
    endtask

    task automatic t_write_qual();
        logic [15:0] v;
        wr(8'h00, 8'hFF);
        @(negedge clk);
        addr = 8'h00; wdata = 8'h70; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        check("R2 no read data while we_n low", rdata, 16'h0);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        rd(8'h00, v);
        check("R2 write with oe_n low ignored", v, ARR);
    endtask

    task automatic t_program();
        logic [15:0] v;
        wr(8'h80, 8'h40);
        check("R5 no job after setup only", 16'(busy), 16'h0);
        wr(8'h85, 8'h3C);
        repeat (N - 1) @(negedge clk);
        check("R5 busy through last cycle", 16'(busy), 16'h1);
        @(negedge clk);
        check("R5 idle after BUSY_CYCLES", 16'(busy), 16'h0);
        rd(8'h80, v);
        check("R5 status mode after program", v, 16'h0080);
        wr(8'h80, 8'hC0);
        wr(8'h81, 8'h01);
        check("R5 C0h starts program job", 16'(busy), 16'h1);
        rd(8'h81, v);
        check("R5 job partition not ready", v, 16'h0000);
        rd(8'h01, v);
        check("R4 other partition ready", v, 16'h0080);
        wait_idle();
    endtask

    task automatic t_lockout();
        logic [15:0] v;
        wr(8'h00, 8'h10);
        wr(8'h02, 8'h77);
        wr(8'h00, 8'hFF);
        rd(8'h00, v);
        check("R8 FFh ignored while busy", v, 16'h0000);
        wr(8'h00, 8'h20);
        wait_idle();
        wr(8'h00, 8'hD0);
        check("R8 20h ignored while busy", 16'(busy), 16'h0);
        rd(8'h00, v);
        check("R8 status after lockout", v, 16'h0080);
    endtask

    task automatic t_erase();
        logic [15:0] v;
        wr(8'h00, 8'h20);
        wr(8'h00, 8'hD0);
        check("R6 erase job started", 16'(busy), 16'h1);
        rd(8'h00, v);
        check("R6 status during erase", v, 16'h0000);
        wait_idle();
        rd(8'h00, v);
        check("R6 ready after erase", v, 16'h0080);
    endtask

    task automatic t_bad_erase();
        logic [15:0] v;
        wr(8'h90, 8'h20);
        wr(8'h90, 8'h55);
        check("R7 no job on bad confirm", 16'(busy), 16'h0);
        rd(8'h90, v);
        check("R7 error bits in part1", v, 16'h00B0);
        rd(8'h10, v);
        check("R7 part0 untouched", v, 16'h0080);
        wr(8'h00, 8'h20);
        wr(8'h00, 8'hFF);
        rd(8'h00, v);
        check("R7 error bits in part0", v, 16'h00B0);
        wr(8'h00, 8'h50);
        wr(8'h00, 8'h70);
        rd(8'h00, v);
        check("R10 part0 cleared", v, 16'h0080);
        rd(8'h80, v);
        check("R10 part1 cleared", v, 16'h0080);
    endtask

    task automatic t_suspend();
        logic [15:0] v;
        wr(8'h00, 8'h20);
        wr(8'h00, 8'hD0);
        repeat (2) @(negedge clk);
        wr(8'h00, 8'hB0);
        rd(8'h00, v);
        check("R9 erase suspended status", v, 16'h00C0);
        repeat (3 * N) @(negedge clk);
        check("R9 countdown frozen", 16'(busy), 16'h1);
        wr(8'h00, 8'hFF);
        rd(8'h00, v);
        check("R9 array read while suspended", v, ARR);
        wr(8'h00, 8'hD0);
        rd(8'h00, v);
        check("R9 resumed erase status", v, 16'h0000);
        repeat (N + 1) @(negedge clk);
        check("R9 erase finishes after resume", 16'(busy), 16'h0);
        wr(8'h80, 8'h40);
        wr(8'h80, 8'h11);
        wr(8'h80, 8'hB0);
        rd(8'h80, v);
        check("R9 program suspended status", v, 16'h0084);
        wr(8'h80, 8'hD0);
        repeat (N + 1) @(negedge clk);
        rd(8'h80, v);
        check("R9 program done after resume", v, 16'h0080);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        wr(8'h00, 8'h90);
        rd(8'h00, v);
        check("R11 maker word", v, 16'h00E5);
        rd(8'h01, v);
        check("R11 device word", v, 16'h7A31);
        wr(8'h00, 8'h98);
        rd(8'h00, v);
        check("R11 query byte 0", v, 16'h0051);
        rd(8'h01, v);
        check("R11 query byte 1", v, 16'h0052);
        rd(8'h02, v);
        check("R11 query byte 2", v, 16'h0059);
        rd(8'h03, v);
        check("R11 query byte 3", v, 16'h0000);
    endtask

    task automatic t_protect();
        logic [15:0] v;
        wr(8'h00, 8'h70);
        wr(8'h00, 8'h60);
        wr(8'h00, 8'h01);
        check("R13 no job after 60h pair", 16'(busy), 16'h0);
        rd(8'h00, v);
        check("R13 array mode after 60h pair", v, ARR);
    endtask

    task automatic t_bus_reset();
        logic [15:0] v;
        wr(8'h00, 8'h20);
        wr(8'h00, 8'h33);
        wr(8'h80, 8'h40);
        wr(8'h80, 8'h22);
        @(negedge clk);
        brst_n = 1'b0;
        @(negedge clk);
        brst_n = 1'b1;
        check("R12 job aborted", 16'(busy), 16'h0);
        rd(8'h00, v);
        check("R12 array mode after bus reset", v, ARR);
        wr(8'h00, 8'h70);
        rd(8'h00, v);
        check("R12 errors cleared", v, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_qual();
        t_program();
        t_lockout();
        t_erase();
        t_bad_erase();
        t_suspend();
        t_ident();
        t_protect();
        t_bus_reset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule